// File: doc/BRIEF.md
# Open-Row SDRAM Command Sequencer

This block turns single-word processor requests into SDRAM command streams for one bank. It leaves the last activated row open after each access and holds its number in a register. A later request to the same row goes straight to the column command. A request to a different row, or a cycle with no request while the row is open, closes the row with a precharge.

The requester raises `req` and holds `req`, `rw`, `addr` and `wdata` steady until `ready` rises. `ready` marks completion. For a write it rises in the cycle that carries the WRITE command. For a read it rises in the cycle that presents the captured data on `rdata`. The address splits into a row part in the upper `ROW_W` bits and a column part in the lower `COL_W` bits. `sd_addr` carries whichever part the current command needs, zero-extended. All outputs are registered.

Top module: `sdr_open_row_seq`

## Requirements
- R1: During and right after reset, `sd_cmd` is NOP (code 0), `ready` is 0 and `rdata` is 0. Command codes are: NOP=0, ACTIVATE=1, READ=2, WRITE=3, PRECHARGE=4, STOP=5.
- R2: With no row open and `req` low, every cycle shows NOP with `ready` low.
- R3: A request while no row is open produces one ACTIVATE cycle with the row part (`addr[ROW_W+COL_W-1:COL_W]`) on `sd_addr`, then one NOP cycle. The request is served in the cycle after that.
- R4: A read to the open row (`rw`=1) produces one READ cycle with the column part (`addr[COL_W-1:0]`) on `sd_addr`. It is followed by `RD_LAT` NOP cycles with `ready` low. In the next cycle `ready` is 1 and `rdata` holds the `sd_rdata` word that was valid `RD_LAT` cycles after the READ cycle.
- R5: A write to the open row (`rw`=0) produces one WRITE cycle with the column part on `sd_addr`, `wdata` on `sd_wdata` and `ready` high. The next cycle is STOP with `ready` low.
- R6: When the row is open and `req` is low, the block issues PRECHARGE with `ready` low and then shows NOP until a new request arrives.
- R7: A request to a row other than the open one gives PRECHARGE, then ACTIVATE of the new row, then NOP, then the column command. A request to the open row issues no ACTIVATE. No ACTIVATE ever occurs while a row is open.
- R8: `ready` is only high in a WRITE cycle or in a NOP cycle delivering read data. A write's `ready` is followed by a cycle with `ready` low.
- R9: Changes of `addr`, `wdata` or `rw` during the read wait cycles do not affect the commands or the captured `rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request valid, held until `ready` |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | ROW_W+COL_W | Row part in upper bits, column part in lower bits |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Captured read data |
| ready | output | 1 | One-cycle completion pulse |
| sd_cmd | output | 3 | SDRAM command code |
| sd_addr | output | max(ROW_W,COL_W) | Row or column address for the command |
| sd_wdata | output | DATA_W | Data for WRITE |
| sd_rdata | input | DATA_W | Data returned by the SDRAM |

## Verification
The assertions assume the requester obeys the hold rule: request fields stay fixed from `req` rising until `ready`. They also assume the SDRAM side delivers read data exactly `RD_LAT` cycles after a READ. The bench keeps to both rules. Each directed task drives one request and holds it until the expected `ready` cycle. The only exception is the deliberate perturbation of fields during read wait cycles, which the block does not sample. The bench's behavioural memory returns data through a pipeline exactly `RD_LAT` deep. It also tracks the open row from the commands it sees, so a read can only match earlier writes if every ACTIVATE, PRECHARGE and column address was correct.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_ACT  = 3'd1,
        CMD_RD   = 3'd2,
        CMD_WR   = 3'd3,
        CMD_PRE  = 3'd4,
        CMD_STOP = 3'd5
    } sdr_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACT_WAIT,
        ST_ROW_ACT,
        ST_RD_WAIT,
        ST_WR_STOP
    } sdr_state_e;

endpackage

// File: rtl/sdr_addr_split.sv
module sdr_addr_split #(
    parameter int ROW_W = 4,
    parameter int COL_W = 4
) (
    input  logic [ROW_W+COL_W-1:0] addr,
    input  logic [ROW_W-1:0]       open_row,
    output logic [ROW_W-1:0]       row,
    output logic [COL_W-1:0]       col,
    output logic                   hit
);
    assign row = addr[ROW_W+COL_W-1:COL_W];
    assign col = addr[COL_W-1:0];
    assign hit = (row == open_row);
endmodule

// File: rtl/sdr_lat_timer.sv
module sdr_lat_timer #(
    parameter int LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int CW = $clog2(LAT + 1) + 1;

    logic [CW-1:0] cnt_d, cnt_q;
    logic          run_d, run_q;

    assign done = run_q && (cnt_q == CW'(LAT));

    always_comb begin
        cnt_d = cnt_q;
        run_d = run_q;
        if (start) begin
            cnt_d = '0;
            run_d = 1'b1;
        end else if (done) begin
            run_d = 1'b0;
        end else if (run_q) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            run_q <= run_d;
        end
    end
endmodule

// File: rtl/sdr_open_row_seq.sv
module sdr_open_row_seq
    import sdr_seq_pkg::*;
#(
    parameter int ROW_W  = 4,
    parameter int COL_W  = 4,
    parameter int DATA_W = 16,
    parameter int RD_LAT = 2
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   req,
    input  logic                                   rw,
    input  logic [ROW_W+COL_W-1:0]                 addr,
    input  logic [DATA_W-1:0]                      wdata,
    output logic [DATA_W-1:0]                      rdata,
    output logic                                   ready,
    output logic [2:0]                             sd_cmd,
    output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] sd_addr,
    output logic [DATA_W-1:0]                      sd_wdata,
    input  logic [DATA_W-1:0]                      sd_rdata
);
    localparam int SA_W = (ROW_W > COL_W) ? ROW_W : COL_W;

    typedef struct packed {
        sdr_state_e         st;
        logic [ROW_W-1:0]   open_row;
        sdr_cmd_e           cmd;
        logic [SA_W-1:0]    sd_addr;
        logic [DATA_W-1:0]  sd_wdata;
        logic [DATA_W-1:0]  rdata;
        logic               ready;
    } seq_t;

    seq_t r_d, r_q;

    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;
    logic             hit;
    logic             tmr_start;
    logic             tmr_done;
    logic [SA_W-1:0]  row_ext;
    logic [SA_W-1:0]  col_ext;

    sdr_addr_split #(.ROW_W(ROW_W), .COL_W(COL_W)) u_split (
        .addr     (addr),
        .open_row (r_q.open_row),
        .row      (row),
        .col      (col),
        .hit      (hit)
    );

    sdr_lat_timer #(.LAT(RD_LAT)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .done  (tmr_done)
    );

    always_comb begin
        row_ext = '0;
        row_ext[ROW_W-1:0] = row;
        col_ext = '0;
        col_ext[COL_W-1:0] = col;
    end

    always_comb begin
        r_d       = r_q;
        r_d.cmd   = CMD_NOP;
        r_d.ready = 1'b0;
        tmr_start = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req) begin
                    r_d.cmd      = CMD_ACT;
                    r_d.sd_addr  = row_ext;
                    r_d.open_row = row;
                    r_d.st       = ST_ACT_WAIT;
                end
            end
            ST_ACT_WAIT: begin
                r_d.st = ST_ROW_ACT;
            end
            ST_ROW_ACT: begin
                if (req && hit) begin
                    r_d.sd_addr = col_ext;
                    if (rw) begin
                        r_d.cmd   = CMD_RD;
                        r_d.st    = ST_RD_WAIT;
                        tmr_start = 1'b1;
                    end else begin
                        r_d.cmd      = CMD_WR;
                        r_d.sd_wdata = wdata;
                        r_d.ready    = 1'b1;
                        r_d.st       = ST_WR_STOP;
                    end
                end else begin
                    r_d.cmd = CMD_PRE;
                    r_d.st  = ST_IDLE;
                end
            end
            ST_RD_WAIT: begin
                if (tmr_done) begin
                    r_d.rdata = sd_rdata;
                    r_d.ready = 1'b1;
                    r_d.st    = ST_ROW_ACT;
                end
            end
            ST_WR_STOP: begin
                r_d.cmd = CMD_STOP;
                r_d.st  = ST_ROW_ACT;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st       <= ST_IDLE;
            r_q.open_row <= '0;
            r_q.cmd      <= CMD_NOP;
            r_q.sd_addr  <= '0;
            r_q.sd_wdata <= '0;
            r_q.rdata    <= '0;
            r_q.ready    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sd_cmd   = r_q.cmd;
    assign sd_addr  = r_q.sd_addr;
    assign sd_wdata = r_q.sd_wdata;
    assign rdata    = r_q.rdata;
    assign ready    = r_q.ready;
endmodule

// File: rtl/sdr_seq_chk.sv
module sdr_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] sd_cmd,
    input logic       ready
);
    localparam logic [2:0] C_NOP  = 3'd0;
    localparam logic [2:0] C_ACT  = 3'd1;
    localparam logic [2:0] C_RD   = 3'd2;
    localparam logic [2:0] C_WR   = 3'd3;
    localparam logic [2:0] C_PRE  = 3'd4;
    localparam logic [2:0] C_STOP = 3'd5;

    logic open_q;

    always_ff @(posedge clk) begin
        if (!rst_n) open_q <= 1'b0;
        else if (sd_cmd == C_ACT) open_q <= 1'b1;
        else if (sd_cmd == C_PRE) open_q <= 1'b0;
    end

    p_act_nop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sd_cmd == C_ACT |=> sd_cmd == C_NOP);

    p_wr_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sd_cmd == C_WR |-> ready);

    p_wr_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sd_cmd == C_WR |=> (sd_cmd == C_STOP && !ready));

    p_pre_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sd_cmd == C_PRE |=> (sd_cmd == C_NOP || sd_cmd == C_ACT));

    p_act_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sd_cmd == C_ACT |-> !open_q);

    p_col_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == C_RD || sd_cmd == C_WR) |-> open_q);

    p_ready_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (sd_cmd == C_WR || sd_cmd == C_NOP));
endmodule

bind sdr_open_row_seq sdr_seq_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .sd_cmd (sd_cmd),
    .ready  (ready)
);

// File: tb/sim_sdr_open_row_seq.sv
module sim_sdr_open_row_seq;
    localparam int ROW_W  = 4;
    localparam int COL_W  = 4;
    localparam int DATA_W = 16;
    localparam int RD_LAT = 2;
    localparam int DEPTH  = 1 << (ROW_W + COL_W);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req = 1'b0;
    logic              rw = 1'b0;
    logic [7:0]        addr = '0;
    logic [15:0]       wdata = '0;
    logic [15:0]       rdata;
    logic              ready;
    logic [2:0]        sd_cmd;
    logic [3:0]        sd_addr;
    logic [15:0]       sd_wdata;
    logic [15:0]       sd_rdata;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    sdr_open_row_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .RD_LAT(RD_LAT)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .rw(rw), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ready(ready), .sd_cmd(sd_cmd), .sd_addr(sd_addr),
        .sd_wdata(sd_wdata), .sd_rdata(sd_rdata)
    );

    // behavioural SDRAM model
    logic [15:0] mem [DEPTH];
    logic [15:0] exp_mem [DEPTH];
    logic [15:0] pipe [RD_LAT];
    logic        m_open = 1'b0;
    logic [3:0]  m_row = '0;
    int          act_cnt = 0;
    int          proto_err = 0;

    assign sd_rdata = pipe[RD_LAT-1];

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mem[i]     = 16'(i * 16'h0101) ^ 16'h5A5A;
            exp_mem[i] = 16'(i * 16'h0101) ^ 16'h5A5A;
        end
        for (int i = 0; i < RD_LAT; i++) pipe[i] = 16'hDEAD;
    end

    always @(posedge clk) begin
        if (rst_n) begin
            pipe[0] <= (sd_cmd == 3'd2) ? mem[{m_row, sd_addr}] : 16'hDEAD;
            for (int i = 1; i < RD_LAT; i++) pipe[i] <= pipe[i-1];
            case (sd_cmd)
                3'd1: begin
                    if (m_open) proto_err <= proto_err + 1;
                    m_open  <= 1'b1;
                    m_row   <= sd_addr;
                    act_cnt <= act_cnt + 1;
                end
                3'd4: m_open <= 1'b0;
                3'd2: if (!m_open) proto_err <= proto_err + 1;
                3'd3: begin
                    if (!m_open) proto_err <= proto_err + 1;
                    mem[{m_row, sd_addr}] <= sd_wdata;
                end
                default: ;
            endcase
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, expv);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // kind: 0 = no row open, 1 = hit, 2 = miss
    task automatic xfer(input bit is_rd, input logic [3:0] row, input logic [3:0] col,
                        input logic [15:0] wd, input int kind, input bit noise);
        int acts0;
        acts0 = act_cnt;
        req = 1'b1; rw = is_rd; addr = {row, col}; wdata = wd;
        if (kind == 2) begin
            step();
            chk(sd_cmd == 3'd4 && !ready, "R7", "miss precharge", int'(sd_cmd), 4);
        end
        if (kind != 1) begin
            step();
            chk(sd_cmd == 3'd1, "R3", "activate cmd", int'(sd_cmd), 1);
            chk(sd_addr == row, "R3", "activate row", int'(sd_addr), int'(row));
            step();
            chk(sd_cmd == 3'd0 && !ready, "R3", "nop after activate", int'(sd_cmd), 0);
        end
        step();
        if (kind == 1)
            chk(act_cnt == acts0, "R7", "no activate on hit", act_cnt, acts0);
        if (is_rd) begin
            chk(sd_cmd == 3'd2 && sd_addr == col && !ready, "R4", "read cmd/col",
                int'({sd_cmd, sd_addr}), int'({3'd2, col}));
            for (int i = 0; i < RD_LAT; i++) begin
                if (noise) begin
                    addr = ~addr; wdata = ~wdata; rw = ~rw;
                end
                step();
                chk(sd_cmd == 3'd0 && !ready, noise ? "R9" : "R4", "read wait",
                    int'({ready, sd_cmd}), 0);
            end
            step();
            chk(ready == 1'b1, "R4", "read ready", int'(ready), 1);
            chk(rdata == exp_mem[{row, col}], noise ? "R9" : "R4", "read data",
                int'(rdata), int'(exp_mem[{row, col}]));
        end else begin
            chk(sd_cmd == 3'd3 && sd_addr == col && sd_wdata == wd && ready, "R5",
                "write cycle", int'({ready, sd_cmd, sd_addr}), int'({1'b1, 3'd3, col}));
            exp_mem[{row, col}] = wd;
            req = 1'b0;
            step();
            chk(sd_cmd == 3'd5 && !ready, "R5", "stop after write", int'({ready, sd_cmd}), 5);
            chk(!ready, "R8", "ready single after write", int'(ready), 0);
        end
        req = 1'b0;
    endtask

    task automatic close_row();
        req = 1'b0;
        step();
        chk(sd_cmd == 3'd4 && !ready, "R6", "precharge when idle", int'({ready, sd_cmd}), 4);
        chk(!ready, "R8", "ready dropped", int'(ready), 0);
        step();
        chk(sd_cmd == 3'd0 && !ready, "R6", "nop after precharge", int'(sd_cmd), 0);
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            step();
            chk(sd_cmd == 3'd0 && !ready, "R2", "idle nop", int'({ready, sd_cmd}), 0);
        end
    endtask

    initial begin
        repeat (3) step();
        chk(sd_cmd == 3'd0 && !ready && rdata == 16'h0, "R1", "reset state",
            int'({ready, sd_cmd}), 0);
        rst_n = 1'b1;
        step();
        chk(sd_cmd == 3'd0 && !ready && rdata == 16'h0, "R1", "after reset",
            int'({ready, sd_cmd}), 0);
        idle_cycles(3);
        xfer(1'b0, 4'd3, 4'd5, 16'hBEEF, 0, 1'b0);
        xfer(1'b0, 4'd3, 4'd9, 16'h1234, 1, 1'b0);
        xfer(1'b1, 4'd3, 4'd5, 16'h0000, 1, 1'b0);
        xfer(1'b1, 4'd3, 4'd9, 16'h0000, 1, 1'b1);
        close_row();
        idle_cycles(2);
        xfer(1'b1, 4'd3, 4'd5, 16'h0000, 0, 1'b0);
        xfer(1'b0, 4'd7, 4'd5, 16'hC0DE, 2, 1'b0);
        xfer(1'b1, 4'd3, 4'd5, 16'h0000, 2, 1'b0);
        xfer(1'b1, 4'd7, 4'd5, 16'h0000, 2, 1'b0);
        xfer(1'b1, 4'd7, 4'd5, 16'h0000, 1, 1'b0);
        xfer(1'b1, 4'd2, 4'd0, 16'h0000, 2, 1'b0);
        close_row();
        idle_cycles(2);
        chk(proto_err == 0, "R7", "activate only when closed", proto_err, 0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule